// File: doc/BRIEF.md
# Dual-Battery Charge Select Watchdog

This block decides which of two batteries may take charge current. A host writes a two-bit selection mask through a register write strobe. Bit 0 of the mask selects battery A and bit 1 selects battery B. Both bits may be set at once, which enables both charge switches together. The mask of 2'b00 selects no battery.

A charge-switch enable is raised only when three things hold: the battery's bit is set in the stored mask, the external input-power comparator reports enough supply, and the host has refreshed the selection recently enough. Every host write reloads a watchdog counter to its full period of `WDOG_CYCLES` clock cycles. If the host stops writing, the counter runs out. The stored mask is then wiped, and charging stays off until the host writes again.

The control is a two-state machine with the states `WD_EXPIRED` and `WD_ARMED`. Reset enters `WD_EXPIRED`.
- Transition WRITE: any host write moves either state to `WD_ARMED` and reloads the counter.
- Transition TIMEOUT: while in `WD_ARMED`, a cycle with the counter at zero and no write moves to `WD_EXPIRED` and clears the mask.
- A cycle with no write and no timeout keeps the current state.

Top module: `chgsel_top`

## Requirements
- R1: While reset is held and after its release, both enables and `chg_active` are 0 and `wdog_expired` is 1.
- R2: A write (`sel_wr`=1 at a rising edge) stores `sel_data` and clears `wdog_expired` after that edge. Bit 0 of the stored value drives `chg_en_a` and bit 1 drives `chg_en_b`.
- R3: With `sel_data`=2'b11 written and `pwr_ok`=1, both enables are 1 in the same cycle.
- R4: While `pwr_ok` is 0, both enables are 0 in that same cycle. The stored selection is kept, so the enables return when `pwr_ok` rises again, without a new write.
- R5: After a write edge with no later write, the selection stays in force for `WDOG_CYCLES` cycles. At the `WDOG_CYCLES`-th edge after the write, the watchdog expires.
- R6: Every write reloads the full period, including a write of the same value and a write on the very edge where expiry would occur. Write takes priority over expiry.
- R7: On expiry the stored selection becomes 2'b00 and `wdog_expired` becomes 1. Both stay that way, whatever `pwr_ok` does, until the next write.
- R8: `chg_active` is 1 exactly when at least one enable is 1.
- R9: A write of 2'b00 arms the watchdog and clears `wdog_expired` while both enables stay 0. If no further write follows, it expires again after the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Host write strobe for the selection register |
| sel_data | input | 2 | Selection mask; bit 0 selects battery A, bit 1 selects battery B |
| pwr_ok | input | 1 | Input power is adequate (from an external comparator) |
| chg_en_a | output | 1 | Charge switch enable for battery A |
| chg_en_b | output | 1 | Charge switch enable for battery B |
| chg_active | output | 1 | At least one battery is being charged |
| wdog_expired | output | 1 | The watchdog has run out; set until the next write |

## Verification
The assertions assume the following about the inputs:
- `sel_wr`, `sel_data` and `pwr_ok` are synchronous to `clk` and settle well before each rising edge.
- `sel_wr` is held low during reset, so that the properties using `$past` see a quiet history.

The stimulus honours this by changing every input only on the falling clock edge, and by keeping the write strobe low through reset. It shrinks the period to 16 cycles, so that expiry, refresh on the expiry edge and expired-state idling can all be reached within a short run.

// File: rtl/chgsel_pkg.sv
package chgsel_pkg;

    localparam int unsigned BAT_COUNT = 2;

    typedef logic [BAT_COUNT-1:0] bat_mask_t;

    typedef enum logic {
        WD_EXPIRED = 1'b0,
        WD_ARMED   = 1'b1
    } wd_state_e;

endpackage

// File: rtl/chgsel_wdog_timer.sv
module chgsel_wdog_timer #(
    parameter int unsigned WDOG_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic run,
    output logic at_zero
);
    localparam int unsigned CW = (WDOG_CYCLES > 2) ? $clog2(WDOG_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD_VAL = CW'(WDOG_CYCLES - 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (reload) begin
            count_q <= RELOAD_VAL;
        end else if (run && count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign at_zero = (count_q == '0);

    // R6
    reload_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> count_q == RELOAD_VAL);

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && count_q == '0) |=> count_q == '0);

endmodule

// File: rtl/chgsel_fsm.sv
module chgsel_fsm
    import chgsel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  bat_mask_t wr_sel,
    input  logic      tmr_zero,
    output bat_mask_t sel_q,
    output logic      armed
);
    wd_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_EXPIRED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_EXPIRED: if (wr) state_d = WD_ARMED;
            WD_ARMED: begin
                if (wr)            state_d = WD_ARMED;
                else if (tmr_zero) state_d = WD_EXPIRED;
            end
            default: state_d = WD_EXPIRED;
        endcase
    end

    // stored selection (output process)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr) begin
            sel_q <= wr_sel;
        end else if (state_q == WD_ARMED && tmr_zero) begin
            sel_q <= '0;
        end
    end

    assign armed = (state_q == WD_ARMED);

    // R2
    write_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (sel_q == $past(wr_sel)) && armed);

    // R5
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tmr_zero && !wr) |=> !armed && sel_q == '0);

    // R7
    expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !wr) |=> !armed && sel_q == '0);

endmodule

// File: rtl/chgsel_gate.sv
module chgsel_gate
    import chgsel_pkg::*;
(
    input  bat_mask_t sel,
    input  logic      pwr_ok,
    input  logic      armed,
    output bat_mask_t en
);
    for (genvar i = 0; i < BAT_COUNT; i++) begin : g_bat
        assign en[i] = sel[i] & pwr_ok & armed;
    end
endmodule

// File: rtl/chgsel_top.sv
module chgsel_top
    import chgsel_pkg::*;
#(
    parameter int unsigned WDOG_CYCLES = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [1:0] sel_data,
    input  logic       pwr_ok,
    output logic       chg_en_a,
    output logic       chg_en_b,
    output logic       chg_active,
    output logic       wdog_expired
);
    bat_mask_t sel_q;
    bat_mask_t en;
    logic      armed;
    logic      tmr_zero;

    chgsel_wdog_timer #(.WDOG_CYCLES(WDOG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (sel_wr),
        .run     (armed),
        .at_zero (tmr_zero)
    );

    chgsel_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (sel_wr),
        .wr_sel   (sel_data),
        .tmr_zero (tmr_zero),
        .sel_q    (sel_q),
        .armed    (armed)
    );

    chgsel_gate u_gate (
        .sel    (sel_q),
        .pwr_ok (pwr_ok),
        .armed  (armed),
        .en     (en)
    );

    assign chg_en_a     = en[0];
    assign chg_en_b     = en[1];
    assign chg_active   = |en;
    assign wdog_expired = !armed;

    // R4
    pwr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> !chg_en_a && !chg_en_b);

    // R8
    active_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_active |-> !wdog_expired);

    // R3
    dual_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_wr) && $past(sel_data) == 2'b11 && pwr_ok) |-> chg_en_a && chg_en_b);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> wdog_expired && !chg_active);

endmodule

// File: tb/tb_chgsel_top.sv
`timescale 1ns/1ps
module tb_chgsel_top;
    localparam int W = 16;
    localparam real HALF = 4.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_wr = 1'b0;
    logic [1:0] sel_data = 2'b00;
    logic pwr_ok = 1'b0;
    logic chg_en_a, chg_en_b, chg_active, wdog_expired;

    int total = 0;
    int bad = 0;

    // behavioural reference state
    int ref_sel = 0;
    int ref_cnt = 0;
    bit ref_exp = 1'b1;
    string tag = "R1";

    always #(HALF) clk = ~clk;

    chgsel_top #(.WDOG_CYCLES(W)) dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_data(sel_data),
        .pwr_ok(pwr_ok), .chg_en_a(chg_en_a), .chg_en_b(chg_en_b),
        .chg_active(chg_active), .wdog_expired(wdog_expired)
    );

    task automatic compare();
        bit ea, eb, act;
        ea  = (ref_sel % 2 == 1) && pwr_ok && !ref_exp;
        eb  = (ref_sel / 2 == 1) && pwr_ok && !ref_exp;
        act = ea || eb;
        total++;
        if (chg_en_a !== ea || chg_en_b !== eb || chg_active !== act || wdog_expired !== ref_exp) begin
            bad++;
            $display("FAIL %s: actual a=%b b=%b act=%b exp=%b expected a=%b b=%b act=%b exp=%b",
                     tag, chg_en_a, chg_en_b, chg_active, wdog_expired, ea, eb, act, ref_exp);
        end
    endtask

    task automatic step(input bit w, input int d, input bit p);
        @(negedge clk);
        sel_wr = w;
        sel_data = 2'(d);
        pwr_ok = p;
        #1;
        compare();
        @(posedge clk);
        if (!rst_n) begin
            ref_sel = 0; ref_exp = 1'b1; ref_cnt = 0;
        end else if (w) begin
            ref_sel = d; ref_cnt = W - 1; ref_exp = 1'b0;
        end else if (!ref_exp) begin
            if (ref_cnt == 0) begin
                ref_exp = 1'b1; ref_sel = 0;
            end else begin
                ref_cnt--;
            end
        end
    endtask

    task automatic idle(input int n, input bit p);
        for (int i = 0; i < n; i++) step(1'b0, 0, p);
    endtask

    initial begin
        #(8.0 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state, also with inputs active
        tag = "R1";
        step(1'b0, 3, 1'b1);
        step(1'b0, 3, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        idle(2, 1'b1);

        // R2: battery A, then battery B
        tag = "R2";
        step(1'b1, 1, 1'b1);
        idle(3, 1'b1);
        step(1'b1, 2, 1'b1);
        idle(3, 1'b1);

        // R3 / R8: both batteries
        tag = "R3";
        step(1'b1, 3, 1'b1);
        idle(2, 1'b1);

        // R4: power drop keeps selection
        tag = "R4";
        idle(3, 1'b0);
        idle(2, 1'b1);

        // R5: expiry after full period
        tag = "R5";
        step(1'b1, 3, 1'b1);
        idle(W + 3, 1'b1);

        // R7: stays expired whatever pwr_ok does
        tag = "R7";
        idle(3, 1'b0);
        idle(3, 1'b1);

        // R9: write of none arms but keeps enables low
        tag = "R9";
        step(1'b1, 0, 1'b1);
        idle(W + 2, 1'b1);

        // R6: same-value refresh, including on the expiry edge
        tag = "R6";
        step(1'b1, 1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            idle(W - 1, 1'b1);
            step(1'b1, 1, 1'b1);
        end
        idle(W / 2, 1'b1);
        step(1'b1, 2, 1'b0);
        idle(W + 2, 1'b1);

        // R8: activity flag across a mix
        tag = "R8";
        step(1'b1, 3, 1'b1);
        step(1'b0, 0, 1'b0);
        step(1'b1, 1, 1'b1);
        idle(2, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule